// File: doc/BRIEF.md
# Backplane Address/Data Slice with Slot Match

This block is a 16-bit slice that sits between a board's separate local address and local data buses and a shared backplane on which address and data take turns on the same active-low lines. Going from the backplane to the board, two capture registers take the backplane value: one holds the address, the other holds the data. Going from the board to the backplane, two holding latches keep the local address and the local data. A select input then picks which of the two is driven out. Every bit that crosses between the board side and the backplane side is inverted, so the board always works in positive logic.

A registered comparator looks at each captured address. In positive logic it checks the top two 4-bit fields against the card's slot number. It reports a hit in the card's standard slot space or in its super-slot space. Both hit flags are active-low. Each tri-state pin group is brought out as a value, a plain input and an output enable. All timing is taken on one system clock. The address and data "clock edges" are single-cycle capture strobes sampled on that clock.

Top module: `bp_addr_data_slice`

## Requirements
- R1: On a clock edge where `addr_cap` is 1, the address capture register takes the bitwise inverse of `bus_in`, and `laddr_out` shows that value from then on. With `addr_cap` at 0, the register keeps its contents.
- R2: On a clock edge where `data_cap` is 1, the data capture register takes the bitwise inverse of `bus_in`, and `ldata_out` shows that value. With `data_cap` at 0, the register keeps its contents, and the address capture register is not affected by `data_cap`.
- R3: `laddr_oe` is 1 exactly while `addr_drv_n` is 0, and `ldata_oe` is 1 exactly while `data_drv_n` is 0.
- R4: While a latch enable (`addr_le_n` or `data_le_n`) is 0, the latch is transparent. The selected backplane output follows the inverse of the live local input in the same cycle.
- R5: While a latch enable is 1, that latch holds the value its local input had at the last rising clock edge at which the enable was 0. Changes on the local input do not reach `bus_out`.
- R6: `sel_data` = 0 routes the address latch to `bus_out` and `sel_data` = 1 routes the data latch. In both cases `bus_out` is the bitwise inverse of the latch content.
- R7: `bus_oe` is 1 exactly while `bus_drv_n` is 0.
- R8: On an address capture, let A be the positive-logic address. `id_hit_n` becomes 0 when A[15:12] is 0000 and A[11:8] equals `slot_id`, and becomes 1 otherwise. It keeps its value until the next address capture, even if `slot_id` changes.
- R9: On an address capture, `super_hit_n` becomes 0 when A[15:12] equals `slot_id` and `slot_id` is nonzero, and becomes 1 otherwise. A `slot_id` of 0 always yields 1. The two hit flags are never both 0.
- R10: While `rst_n` is 0 at a clock edge, both capture registers and both latches clear to zero, and both hit flags go to 1. After reset, `laddr_out` and `ldata_out` read 0 and `bus_out` reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_in | input | 16 | Backplane lines as received (active-low) |
| bus_out | output | 16 | Backplane lines to drive (active-low) |
| bus_oe | output | 1 | Backplane output enable |
| bus_drv_n | input | 1 | Request to drive the backplane, active low |
| addr_cap | input | 1 | Address capture strobe |
| data_cap | input | 1 | Data capture strobe |
| laddr_in | input | 16 | Local address bus as received |
| laddr_out | output | 16 | Local address bus to drive (captured address) |
| laddr_oe | output | 1 | Local address output enable |
| addr_drv_n | input | 1 | Request to drive the local address bus, active low |
| ldata_in | input | 16 | Local data bus as received |
| ldata_out | output | 16 | Local data bus to drive (captured data) |
| ldata_oe | output | 1 | Local data output enable |
| data_drv_n | input | 1 | Request to drive the local data bus, active low |
| addr_le_n | input | 1 | Address latch open, active low |
| data_le_n | input | 1 | Data latch open, active low |
| sel_data | input | 1 | Backplane source: 0 address latch, 1 data latch |
| slot_id | input | 4 | This card's slot number |
| id_hit_n | output | 1 | Standard slot space hit, active low |
| super_hit_n | output | 1 | Super-slot space hit, active low |

## Verification
The assertions assume three things about the inputs. Capture strobes are one-cycle synchronous pulses. `rst_n` is held low from time zero through the first clock edges. `sel_data` and the latch enables change only between clock edges. The bench meets all three by driving every input on the falling clock edge and holding reset low for two edges before releasing it.

The bench uses `slot_id` values and addresses that sit on both sides of each comparison. This includes a slot number of zero, an address whose upper field is nonzero, and a slot change between captures. With these cases the flag-exclusion and hold properties are exercised, not met vacuously.

// File: rtl/bps_pkg.sv
package bps_pkg;
   localparam int unsigned BPS_DEF_W    = 16;
   localparam int unsigned BPS_DEF_ID_W = 4;

   typedef enum logic {
      BPS_SRC_ADDR = 1'b0,
      BPS_SRC_DATA = 1'b1
   } bps_src_e;
endpackage

// File: rtl/bps_capture.sv
// Edge capture of the active-low backplane, stored in positive logic.
module bps_capture #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] bus_n,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= ~bus_n;
   end
endmodule

// File: rtl/bps_hold_latch.sv
// Transparent-low latch built from a register plus a bypass path.
module bps_hold_latch #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         open_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] held;

   always_ff @(posedge clk) begin
      if (!rst_n)       held <= '0;
      else if (!open_n) held <= d;
   end

   assign q = open_n ? held : d;
endmodule

// File: rtl/bps_slot_cmp.sv
// Registered slot and super-slot decode of a captured address.
module bps_slot_cmp #(
   parameter int unsigned W        = 16,
   parameter int unsigned ID_W     = 4,
   parameter bit          SUPER_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [W-1:0]    bus_n,
   input  logic [ID_W-1:0] slot_id,
   output logic            id_eq_n,
   output logic            super_eq_n
);
   localparam int unsigned TOP_LSB = W - ID_W;
   localparam int unsigned FLD_LSB = W - 2 * ID_W;

   logic [W-1:0]    addr;
   logic [ID_W-1:0] top_fld;
   logic [ID_W-1:0] slot_fld;

   assign addr     = ~bus_n;
   assign top_fld  = addr[TOP_LSB +: ID_W];
   assign slot_fld = addr[FLD_LSB +: ID_W];

   always_ff @(posedge clk) begin
      if (!rst_n)    id_eq_n <= 1'b1;
      else if (load) id_eq_n <= !((top_fld == '0) && (slot_fld == slot_id));
   end

   generate
      if (SUPER_EN) begin : g_super
         always_ff @(posedge clk) begin
            if (!rst_n)    super_eq_n <= 1'b1;
            else if (load) super_eq_n <= !((top_fld == slot_id) && (slot_id != '0));
         end
      end else begin : g_no_super
         assign super_eq_n = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/bp_addr_data_slice.sv
module bp_addr_data_slice
   import bps_pkg::*;
#(
   parameter int unsigned W        = BPS_DEF_W,
   parameter int unsigned ID_W     = BPS_DEF_ID_W,
   parameter bit          SUPER_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W-1:0]    bus_in,
   output logic [W-1:0]    bus_out,
   output logic            bus_oe,
   input  logic            bus_drv_n,
   input  logic            addr_cap,
   input  logic            data_cap,
   input  logic [W-1:0]    laddr_in,
   output logic [W-1:0]    laddr_out,
   output logic            laddr_oe,
   input  logic            addr_drv_n,
   input  logic [W-1:0]    ldata_in,
   output logic [W-1:0]    ldata_out,
   output logic            ldata_oe,
   input  logic            data_drv_n,
   input  logic            addr_le_n,
   input  logic            data_le_n,
   input  logic            sel_data,
   input  logic [ID_W-1:0] slot_id,
   output logic            id_hit_n,
   output logic            super_hit_n
);
   generate
      if (ID_W == 0 || W < 2 * ID_W) begin : g_bad_width
         $error("bp_addr_data_slice: W must hold two slot fields");
      end
   endgenerate

   logic [W-1:0] addr_lat_q;
   logic [W-1:0] data_lat_q;
   bps_src_e     src;

   bps_capture #(.W(W)) u_addr_cap (
      .clk(clk), .rst_n(rst_n), .load(addr_cap), .bus_n(bus_in), .q(laddr_out));

   bps_capture #(.W(W)) u_data_cap (
      .clk(clk), .rst_n(rst_n), .load(data_cap), .bus_n(bus_in), .q(ldata_out));

   bps_hold_latch #(.W(W)) u_addr_lat (
      .clk(clk), .rst_n(rst_n), .open_n(addr_le_n), .d(laddr_in), .q(addr_lat_q));

   bps_hold_latch #(.W(W)) u_data_lat (
      .clk(clk), .rst_n(rst_n), .open_n(data_le_n), .d(ldata_in), .q(data_lat_q));

   bps_slot_cmp #(.W(W), .ID_W(ID_W), .SUPER_EN(SUPER_EN)) u_cmp (
      .clk(clk), .rst_n(rst_n), .load(addr_cap), .bus_n(bus_in),
      .slot_id(slot_id), .id_eq_n(id_hit_n), .super_eq_n(super_hit_n));

   assign src     = bps_src_e'(sel_data);
   assign bus_out = (src == BPS_SRC_DATA) ? ~data_lat_q : ~addr_lat_q;

   assign bus_oe   = !bus_drv_n;
   assign laddr_oe = !addr_drv_n;
   assign ldata_oe = !data_drv_n;
endmodule

// File: rtl/bp_addr_data_slice_chk.sv
module bp_addr_data_slice_chk #(
   parameter int unsigned W    = 16,
   parameter int unsigned ID_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [W-1:0]    bus_in,
   input logic [W-1:0]    bus_out,
   input logic            addr_cap,
   input logic            data_cap,
   input logic [W-1:0]    laddr_out,
   input logic [W-1:0]    ldata_out,
   input logic            addr_le_n,
   input logic            data_le_n,
   input logic            sel_data,
   input logic [ID_W-1:0] slot_id,
   input logic            id_hit_n,
   input logic            super_hit_n
);
   // R1
   addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_cap |=> (laddr_out == ~$past(bus_in)));

   // R2
   data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_cap |=> (ldata_out == ~$past(bus_in)));

   // R8
   hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_cap |=> ($stable(id_hit_n) && $stable(super_hit_n)));

   // R9
   super_zero_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_cap && slot_id == '0) |=> super_hit_n);

   // R9
   hit_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!id_hit_n && !super_hit_n));

   // R5
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_le_n && data_le_n) ##1 (addr_le_n && data_le_n && $stable(sel_data))
      |-> $stable(bus_out));

   // R10
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (id_hit_n && super_hit_n && laddr_out == '0 && ldata_out == '0));
endmodule

bind bp_addr_data_slice bp_addr_data_slice_chk #(.W(W), .ID_W(ID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
   .addr_cap(addr_cap), .data_cap(data_cap), .laddr_out(laddr_out),
   .ldata_out(ldata_out), .addr_le_n(addr_le_n), .data_le_n(data_le_n),
   .sel_data(sel_data), .slot_id(slot_id), .id_hit_n(id_hit_n),
   .super_hit_n(super_hit_n));

// File: tb/bp_addr_data_slice_bench.sv
`timescale 1ns/1ps
module bp_addr_data_slice_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_in = '1;
   logic [15:0] bus_out;
   logic        bus_oe;
   logic        bus_drv_n = 1'b1;
   logic        addr_cap = 1'b0;
   logic        data_cap = 1'b0;
   logic [15:0] laddr_in = '0;
   logic [15:0] laddr_out;
   logic        laddr_oe;
   logic        addr_drv_n = 1'b1;
   logic [15:0] ldata_in = '0;
   logic [15:0] ldata_out;
   logic        ldata_oe;
   logic        data_drv_n = 1'b1;
   logic        addr_le_n = 1'b1;
   logic        data_le_n = 1'b1;
   logic        sel_data = 1'b0;
   logic [3:0]  slot_id = '0;
   logic        id_hit_n;
   logic        super_hit_n;

   always #2.5 clk = ~clk;

   bp_addr_data_slice u_bp_addr_data_slice (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .bus_drv_n(bus_drv_n), .addr_cap(addr_cap), .data_cap(data_cap),
      .laddr_in(laddr_in), .laddr_out(laddr_out), .laddr_oe(laddr_oe),
      .addr_drv_n(addr_drv_n), .ldata_in(ldata_in), .ldata_out(ldata_out),
      .ldata_oe(ldata_oe), .data_drv_n(data_drv_n), .addr_le_n(addr_le_n),
      .data_le_n(data_le_n), .sel_data(sel_data), .slot_id(slot_id),
      .id_hit_n(id_hit_n), .super_hit_n(super_hit_n));

   typedef enum int {S_LADDR, S_LDATA, S_BUS, S_ID, S_SUPER, S_LAOE, S_LDOE, S_BOE} sig_e;
   typedef struct {
      string       req;
      sig_e        sig;
      logic [15:0] exp;
   } item_t;

   item_t q[$];
   event  chk_ev;
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   function automatic logic [15:0] observe(sig_e s);
      case (s)
         S_LADDR: return laddr_out;
         S_LDATA: return ldata_out;
         S_BUS:   return bus_out;
         S_ID:    return {15'd0, id_hit_n};
         S_SUPER: return {15'd0, super_hit_n};
         S_LAOE:  return {15'd0, laddr_oe};
         S_LDOE:  return {15'd0, ldata_oe};
         default: return {15'd0, bus_oe};
      endcase
   endfunction

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = q.pop_front();
            act = observe(it.sig);
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s %s: actual=%h expected=%h", it.req, it.sig.name(), act, it.exp);
            end
         end
      end
   end

   task automatic expect_val(string req, sig_e s, logic [15:0] e);
      item_t it;
      it.req = req; it.sig = s; it.exp = e;
      q.push_back(it);
      -> chk_ev;
      #0.1;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic capture_addr(logic [15:0] logical, logic [3:0] id);
      bus_in = ~logical; slot_id = id; addr_cap = 1'b1;
      tick();
      addr_cap = 1'b0; bus_in = 16'h5A5A;
   endtask

   initial begin
      #50000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      #1;
      // R10 reset state
      expect_val("R10", S_LADDR, 16'h0000);
      expect_val("R10", S_LDATA, 16'h0000);
      expect_val("R10", S_ID, 16'h1);
      expect_val("R10", S_SUPER, 16'h1);
      expect_val("R10", S_BUS, 16'hFFFF);
      // R3 / R7 output enables
      expect_val("R3", S_LAOE, 16'h0);
      expect_val("R7", S_BOE, 16'h0);
      addr_drv_n = 1'b0; bus_drv_n = 1'b0; #1;
      expect_val("R3", S_LAOE, 16'h1);
      expect_val("R3", S_LDOE, 16'h0);
      expect_val("R7", S_BOE, 16'h1);
      data_drv_n = 1'b0; addr_drv_n = 1'b1; #1;
      expect_val("R3", S_LDOE, 16'h1);
      expect_val("R3", S_LAOE, 16'h0);
      tick();

      // R1 / R8 standard slot hit
      capture_addr(16'h0312, 4'd3); #1;
      expect_val("R1", S_LADDR, 16'h0312);
      expect_val("R8", S_ID, 16'h0);
      expect_val("R9", S_SUPER, 16'h1);
      // R1 / R8 hold without capture, slot change ignored
      slot_id = 4'd5; tick(); tick(); #1;
      expect_val("R1", S_LADDR, 16'h0312);
      expect_val("R8", S_ID, 16'h0);
      // R9 super-slot hit
      capture_addr(16'h5ABC, 4'd5); #1;
      expect_val("R9", S_SUPER, 16'h0);
      expect_val("R8", S_ID, 16'h1);
      expect_val("R1", S_LADDR, 16'h5ABC);
      // slot zero: standard hit, super forced inactive
      capture_addr(16'h0000, 4'd0); #1;
      expect_val("R8", S_ID, 16'h0);
      expect_val("R9", S_SUPER, 16'h1);
      capture_addr(16'h0A00, 4'd0); #1;
      expect_val("R8", S_ID, 16'h1);
      expect_val("R9", S_SUPER, 16'h1);
      // field mismatch and nonzero upper field
      capture_addr(16'h0400, 4'd3); #1;
      expect_val("R8", S_ID, 16'h1);
      expect_val("R9", S_SUPER, 16'h1);
      capture_addr(16'h7300, 4'd3); #1;
      expect_val("R8", S_ID, 16'h1);
      expect_val("R9", S_SUPER, 16'h1);
      capture_addr(16'hF123, 4'd15); #1;
      expect_val("R9", S_SUPER, 16'h0);

      // R2 data capture, address register untouched
      bus_in = ~16'hBEEF; data_cap = 1'b1;
      tick();
      data_cap = 1'b0; bus_in = 16'h0000; #1;
      expect_val("R2", S_LDATA, 16'hBEEF);
      expect_val("R2", S_LADDR, 16'hF123);
      tick(); #1;
      expect_val("R2", S_LDATA, 16'hBEEF);

      // R4 / R5 / R6 latches and select
      sel_data = 1'b0; addr_le_n = 1'b0; laddr_in = 16'h1234; #1;
      expect_val("R4", S_BUS, ~16'h1234);
      laddr_in = 16'h4321; #1;
      expect_val("R4", S_BUS, ~16'h4321);
      tick();
      addr_le_n = 1'b1; laddr_in = 16'hFFFF; #1;
      expect_val("R5", S_BUS, ~16'h4321);
      tick(); #1;
      expect_val("R5", S_BUS, ~16'h4321);
      sel_data = 1'b1; data_le_n = 1'b0; ldata_in = 16'hCAFE; #1;
      expect_val("R6", S_BUS, ~16'hCAFE);
      tick();
      data_le_n = 1'b1; ldata_in = 16'h0001; #1;
      expect_val("R5", S_BUS, ~16'hCAFE);
      sel_data = 1'b0; #1;
      expect_val("R6", S_BUS, ~16'h4321);
      tick(); #1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule